// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave Engine

This block is the slave side of a byte-addressed serial EEPROM on a two-wire bus with a 16-bit memory address. It receives SCL and SDA samples that are already synchronized to the system clock. It detects the Start and Stop conditions and checks the select byte against a fixed type code and three strap inputs. It then accepts a two-byte address and either stores data bytes or returns them. SDA is driven only as an open-drain pull-down enable.

Written bytes are first collected in a page buffer. They reach the storage array only after a clean Stop, which begins a timed programming interval. The engine ignores the bus for the whole interval, so a master can find out when programming has finished by repeatedly sending a select byte until it is acknowledged.

A write-lock input lets the select and address bytes through but refuses the data bytes. Reads can start at the current address, at a new address set by a dummy write followed by a repeated Start, or run on as a sequential stream.

Top module: `eep_slave_top`

## Requirements
- R1: A select byte is accepted only if bits 7..4 equal 1010 and bits 3..1 equal `strap_i[2:0]`. Bit 0 is the direction, where 0 means write and 1 means read. A select byte that does not match gets no acknowledge, and the engine returns to idle.
- R2: In a write transfer, the engine acknowledges each accepted byte (select, address high, address low, data) by pulling SDA low during the ninth clock.
- R3: After the select byte, the high address byte comes first and then the low byte. A single data byte followed by Stop is stored at that address.
- R4: A write may carry any number of data bytes, and up to 128 distinct ones are kept. After each byte only address bits 6..0 advance, so the address wraps inside its 128-byte page.
- R5: A Stop after at least one buffered data byte starts a programming interval of `PROG_CYCLES` clocks. During that interval the engine acknowledges nothing, including a select byte sent to poll it.
- R6: While `wr_lock_i` is high, the select and address bytes are still acknowledged. Data bytes get no acknowledge, the array is not changed and no programming interval starts.
- R7: A dummy write of the address, then a repeated Start and a read select byte, returns the byte stored at that address.
- R8: In a read, every byte the master acknowledges moves the full 16-bit address on by one and sends the next byte. The address wraps from 0xFFFF to 0x0000.
- R9: A read select with no address returns the byte that follows the last one accessed.
- R10: A Stop or Start that arrives after two or more bits of a byte have been clocked aborts the transfer. Any data buffered by that write is discarded and not programmed.
- R11: After reset, SDA is released and the engine is idle and ready for a Start.
- R12: A NoAck from the master after a read byte ends the transfer, and the engine releases SDA.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Synchronized serial clock sample |
| sda_i | input | 1 | Synchronized serial data sample (wired bus level) |
| strap_i | input | 3 | Select strap bits matched against select bits 3..1 |
| wr_lock_i | input | 1 | High blocks data bytes of writes |
| sda_pull_o | output | 1 | High pulls SDA low (open-drain enable) |

## Verification
The embedded assertions check several properties on every cycle. The engine stays silent during programming. Only a matching select byte is acknowledged. A locked write never fills the page buffer. A buffered byte never changes the page bits of the address. A Stop in mid-byte always returns the engine to idle. A master NoAck always releases SDA. Other behaviour depends on data passing end to end through the bus, the buffer and the array, so only the bench scenarios can show it. That covers the stored values, the in-page address wrap, the 16-bit wrap of sequential reads, the current-address read and the discarding of aborted writes.

// File: rtl/eep_pkg.sv
package eep_pkg;

    localparam logic [3:0] TYPE_CODE = 4'b1010;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK,
        ST_TX,
        ST_MACK,
        ST_PROG
    } eep_state_e;

    typedef enum logic [1:0] {
        PH_SEL,
        PH_AHI,
        PH_ALO,
        PH_DATA
    } eep_phase_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
    } bus_ev_t;

    function automatic logic sel_match(input logic [6:0] sel, input logic [2:0] strap);
        return (sel[6:3] == TYPE_CODE) && (sel[2:0] == strap);
    endfunction

    function automatic eep_phase_e phase_next(input eep_phase_e ph);
        case (ph)
            PH_SEL:  return PH_AHI;
            PH_AHI:  return PH_ALO;
            default: return PH_DATA;
        endcase
    endfunction

endpackage

// File: rtl/eep_bus_events.sv
module eep_bus_events
    import eep_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev
);
    logic scl_q;
    logic sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    always_comb begin
        ev.start = scl_i & scl_q & sda_q & ~sda_i;
        ev.stop  = scl_i & scl_q & ~sda_q & sda_i;
        ev.rise  = scl_i & ~scl_q;
        ev.fall  = ~scl_i & scl_q;
    end

endmodule

// File: rtl/eep_page_buf.sv
module eep_page_buf #(
    parameter int PAGE_W = 7,
    localparam int NBYTES = 1 << PAGE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              we,
    input  logic [PAGE_W-1:0] waddr,
    input  logic [7:0]        wdata,
    input  logic [PAGE_W-1:0] raddr,
    output logic [7:0]        rdata,
    output logic              rvalid,
    output logic              any_valid
);
    logic [7:0]        bytes [NBYTES];
    logic [NBYTES-1:0] valid;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            valid <= '0;
        end else if (we) begin
            valid[waddr] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (we) begin
            bytes[waddr] <= wdata;
        end
    end

    assign rdata     = bytes[raddr];
    assign rvalid    = valid[raddr];
    assign any_valid = |valid;

endmodule

// File: rtl/eep_mem_array.sv
module eep_mem_array #(
    parameter int         DEPTH = 1024,
    parameter logic [7:0] FILL  = 8'hFF,
    localparam int        AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    logic [7:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                cells[i] <= FILL;
            end
        end else if (we) begin
            cells[waddr] <= wdata;
        end
    end

    assign rdata = cells[raddr];

endmodule

// File: rtl/eep_slave_top.sv
module eep_slave_top
    import eep_pkg::*;
#(
    parameter int         MEM_DEPTH   = 1024,
    parameter int         PAGE_W      = 7,
    parameter int         PROG_CYCLES = 400,
    parameter logic [7:0] ERASED      = 8'hFF
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [2:0] strap_i,
    input  logic       wr_lock_i,
    output logic       sda_pull_o
);
    localparam int AW         = $clog2(MEM_DEPTH);
    localparam int PAGE_BYTES = 1 << PAGE_W;
    localparam int CNT_W      = $clog2(PROG_CYCLES + 1);
    localparam logic [CNT_W-1:0]  PROG_LAST = CNT_W'(PROG_CYCLES - 1);
    localparam logic [CNT_W-1:0]  PG_END    = CNT_W'(PAGE_BYTES);
    localparam logic [PAGE_W-1:0] PG_ONE    = PAGE_W'(1);

    bus_ev_t    ev;
    eep_state_e st;
    eep_phase_e phase;
    logic [7:0]  shreg;
    logic [3:0]  bitcnt;
    logic        ack_drive;
    logic        rd_mode;
    logic        m_ack;
    logic [7:0]  addr_hi;
    logic [15:0] addr;
    logic [CNT_W-1:0] prog_cnt;

    logic       buf_we, buf_clr, buf_rvalid, buf_any;
    logic [7:0] buf_rdata;
    logic       mem_we;
    logic [7:0] mem_rdata;
    logic       go_prog;
    logic       byte_done;
    logic [15:0] addr_in_page;

    eep_bus_events u_ev (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev    (ev)
    );

    eep_page_buf #(.PAGE_W(PAGE_W)) u_buf (
        .clk       (clk),
        .rst       (rst),
        .clr       (buf_clr),
        .we        (buf_we),
        .waddr     (addr[PAGE_W-1:0]),
        .wdata     (shreg),
        .raddr     (prog_cnt[PAGE_W-1:0]),
        .rdata     (buf_rdata),
        .rvalid    (buf_rvalid),
        .any_valid (buf_any)
    );

    eep_mem_array #(.DEPTH(MEM_DEPTH), .FILL(ERASED)) u_mem (
        .clk   (clk),
        .rst   (rst),
        .we    (mem_we),
        .waddr (AW'({addr[15:PAGE_W], prog_cnt[PAGE_W-1:0]})),
        .wdata (buf_rdata),
        .raddr (addr[AW-1:0]),
        .rdata (mem_rdata)
    );

    always_comb begin
        byte_done    = (st == ST_RX) && ev.fall && (bitcnt == 4'd8);
        addr_in_page = {addr[15:PAGE_W], addr[PAGE_W-1:0] + PG_ONE};
        go_prog      = (st == ST_RX) && (phase == PH_DATA) && (bitcnt <= 4'd1) && buf_any;
        buf_we       = byte_done && (phase == PH_DATA) && !wr_lock_i;
        mem_we       = (st == ST_PROG) && (prog_cnt < PG_END) && buf_rvalid;
        if (st == ST_PROG) begin
            buf_clr = (prog_cnt == PROG_LAST);
        end else begin
            buf_clr = ev.start || (ev.stop && !go_prog);
        end
        sda_pull_o = ((st == ST_ACK) && ack_drive) || ((st == ST_TX) && !shreg[7]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            phase     <= PH_SEL;
            shreg     <= '0;
            bitcnt    <= '0;
            ack_drive <= 1'b0;
            rd_mode   <= 1'b0;
            m_ack     <= 1'b0;
            addr_hi   <= '0;
            addr      <= '0;
            prog_cnt  <= '0;
        end else if (st == ST_PROG) begin
            if (prog_cnt == PROG_LAST) begin
                st       <= ST_IDLE;
                prog_cnt <= '0;
            end else begin
                prog_cnt <= prog_cnt + 1'b1;
            end
        end else if (ev.start) begin
            st        <= ST_RX;
            phase     <= PH_SEL;
            bitcnt    <= '0;
            ack_drive <= 1'b0;
        end else if (ev.stop) begin
            st        <= go_prog ? ST_PROG : ST_IDLE;
            prog_cnt  <= '0;
            bitcnt    <= '0;
            ack_drive <= 1'b0;
        end else begin
            case (st)
                ST_RX: begin
                    if (ev.rise && (bitcnt != 4'd8)) begin
                        shreg  <= {shreg[6:0], sda_i};
                        bitcnt <= bitcnt + 1'b1;
                    end else if (byte_done) begin
                        st <= ST_ACK;
                        case (phase)
                            PH_SEL: begin
                                if (sel_match(shreg[7:1], strap_i)) begin
                                    ack_drive <= 1'b1;
                                    rd_mode   <= shreg[0];
                                end else begin
                                    st <= ST_IDLE;
                                end
                            end
                            PH_AHI: begin
                                addr_hi   <= shreg;
                                ack_drive <= 1'b1;
                            end
                            PH_ALO: begin
                                addr      <= {addr_hi, shreg};
                                ack_drive <= 1'b1;
                            end
                            default: begin
                                ack_drive <= !wr_lock_i;
                                if (!wr_lock_i) begin
                                    addr <= addr_in_page;
                                end
                            end
                        endcase
                    end
                end
                ST_ACK: begin
                    if (ev.fall) begin
                        ack_drive <= 1'b0;
                        bitcnt    <= '0;
                        if ((phase == PH_SEL) && rd_mode) begin
                            st    <= ST_TX;
                            shreg <= mem_rdata;
                            addr  <= addr + 16'd1;
                        end else begin
                            st    <= ST_RX;
                            phase <= phase_next(phase);
                        end
                    end
                end
                ST_TX: begin
                    if (ev.fall) begin
                        if (bitcnt == 4'd7) begin
                            st     <= ST_MACK;
                            bitcnt <= '0;
                            m_ack  <= 1'b0;
                        end else begin
                            shreg  <= {shreg[6:0], 1'b0};
                            bitcnt <= bitcnt + 1'b1;
                        end
                    end
                end
                ST_MACK: begin
                    if (ev.rise) begin
                        m_ack <= !sda_i;
                    end else if (ev.fall) begin
                        if (m_ack) begin
                            st     <= ST_TX;
                            shreg  <= mem_rdata;
                            addr   <= addr + 16'd1;
                            bitcnt <= '0;
                        end else begin
                            st <= ST_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // R5: no acknowledge or data drive while programming
    a_r5_silent_prog: assert property (@(posedge clk) disable iff (rst)
        (st == ST_PROG) |-> !sda_pull_o);

    // R1: a select acknowledge only follows a matching select byte
    a_r1_sel_match: assert property (@(posedge clk) disable iff (rst)
        (st == ST_ACK && phase == PH_SEL && ack_drive) |->
            (shreg[7:4] == 4'b1010 && shreg[3:1] == strap_i));

    // R6: a locked write never fills the page buffer
    a_r6_lock_no_buffer: assert property (@(posedge clk) disable iff (rst)
        wr_lock_i |=> !$rose(buf_any));

    // R4: buffering a byte never changes the page part of the address
    a_r4_page_kept: assert property (@(posedge clk) disable iff (rst)
        buf_we |=> (addr[15:PAGE_W] == $past(addr[15:PAGE_W])));

    // R10: a Stop after two or more bits of a byte returns to idle
    a_r10_stop_abort: assert property (@(posedge clk) disable iff (rst)
        (ev.stop && st == ST_RX && bitcnt >= 4'd2) |=> (st == ST_IDLE));

    // R12: a master NoAck ends the read and frees SDA
    a_r12_noack_release: assert property (@(posedge clk) disable iff (rst)
        (st == ST_MACK && ev.fall && !m_ack) |=> (st == ST_IDLE && !sda_pull_o));

endmodule

// File: tb/eep_slave_top_bench.sv
module eep_slave_top_bench;

    localparam int Q         = 4;
    localparam int PROG_WAIT = 500;
    localparam logic [7:0] SEL_W = 8'hAA;
    localparam logic [7:0] SEL_R = 8'hAB;
    // {address, data}
    localparam logic [23:0] VEC [0:5] = '{
        24'h0010_11, 24'h0234_A7, 24'h1155_3C,
        24'h02FE_00, 24'hFFFF_E1, 24'h0000_96
    };

    logic clk = 1'b0;
    logic rst;
    logic scl;
    logic sda_m;
    logic [2:0] strap;
    logic lock;
    logic sda_pull;
    logic sda_bus;
    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    assign sda_bus = sda_m & ~sda_pull;

    eep_slave_top u_eep_slave_top (
        .clk        (clk),
        .rst        (rst),
        .scl_i      (scl),
        .sda_i      (sda_bus),
        .strap_i    (strap),
        .wr_lock_i  (lock),
        .sda_pull_o (sda_pull)
    );

    task automatic chk(input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic hold();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; hold();
        scl = 1'b1;   hold();
        sda_m = 1'b0; hold();
        scl = 1'b0;   hold();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; hold();
        scl = 1'b1;   hold();
        sda_m = 1'b1; hold();
    endtask

    task automatic send_bit(input logic b);
        sda_m = b;  hold();
        scl = 1'b1; hold(); hold();
        scl = 1'b0; hold();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        sda_m = 1'b1; hold();
        scl = 1'b1;   hold();
        ack = !sda_bus;
        hold();
        scl = 1'b0;   hold();
    endtask

    task automatic recv_byte(output logic [7:0] d, input logic give_ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = 1'b1; hold();
            scl = 1'b1;   hold();
            d[i] = sda_bus;
            hold();
            scl = 1'b0;   hold();
        end
        send_bit(!give_ack);
        sda_m = 1'b1;
    endtask

    task automatic write_hdr(input logic [15:0] a, output logic [2:0] acks);
        bus_start();
        send_byte(SEL_W, acks[2]);
        send_byte(a[15:8], acks[1]);
        send_byte(a[7:0], acks[0]);
    endtask

    task automatic read_at(input logic [15:0] a, output logic [3:0] acks);
        write_hdr(a, acks[3:1]);
        bus_start();
        send_byte(SEL_R, acks[0]);
    endtask

    task automatic poll(output logic ack);
        bus_start();
        send_byte(SEL_W, ack);
        bus_stop();
    endtask

    task automatic report();
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog run did not complete");
            report();
        end
    end

    initial begin
        logic [2:0]  a3;
        logic [3:0]  a4;
        logic        ack;
        logic [7:0]  got;
        logic [15:0] va;
        logic [7:0]  vd;

        rst = 1'b1; scl = 1'b1; sda_m = 1'b1; strap = 3'b101; lock = 1'b0;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R11", "SDA released after reset", 16'(sda_pull), 16'd0);

        // table walk: byte write (R2, R3), poll (R5), random read back (R7, R3)
        for (int i = 0; i < 6; i++) begin
            va = VEC[i][23:8];
            vd = VEC[i][7:0];
            write_hdr(va, a3);
            send_byte(vd, ack);
            bus_stop();
            chk("R2", "write byte acks", 16'({a3, ack}), 16'hF);
            poll(ack);
            chk("R5", "no ack while programming", 16'(ack), 16'd0);
            repeat (PROG_WAIT) @(negedge clk);
            read_at(va, a4);
            chk("R7", "random read header acks", 16'(a4), 16'hF);
            recv_byte(got, 1'b0);
            bus_stop();
            chk("R3", "byte read back", 16'(got), 16'(vd));
        end

        // R1: wrong type code and wrong strap get no ack; strap change accepted
        bus_start(); send_byte(8'h2A, ack); bus_stop();
        chk("R1", "wrong type code", 16'(ack), 16'd0);
        bus_start(); send_byte(8'hA4, ack); bus_stop();
        chk("R1", "wrong strap bits", 16'(ack), 16'd0);
        strap = 3'b010;
        bus_start(); send_byte(8'hA4, ack); bus_stop();
        chk("R1", "matching new strap", 16'(ack), 16'd1);
        strap = 3'b101;

        // R8: sequential read wraps 0xFFFF -> 0x0000; R12 release after NoAck
        read_at(16'hFFFF, a4);
        recv_byte(got, 1'b1);
        chk("R8", "byte at top address", 16'(got), 16'hE1);
        recv_byte(got, 1'b0);
        chk("R8", "wrapped to address zero", 16'(got), 16'h96);
        chk("R12", "SDA released after NoAck", 16'(sda_pull), 16'd0);
        bus_stop();

        // R9: current address read follows the last byte accessed
        read_at(16'h0233, a4);
        recv_byte(got, 1'b0);
        bus_stop();
        bus_start(); send_byte(SEL_R, ack);
        recv_byte(got, 1'b0);
        bus_stop();
        chk("R9", "current address read", 16'(got), 16'hA7);

        // R4: page write wraps within its page
        write_hdr(16'h107E, a3);
        send_byte(8'h21, ack); send_byte(8'h22, ack); send_byte(8'h23, ack);
        bus_stop();
        repeat (PROG_WAIT) @(negedge clk);
        read_at(16'h107E, a4);
        recv_byte(got, 1'b1);
        chk("R4", "page byte 0", 16'(got), 16'h21);
        recv_byte(got, 1'b1);
        chk("R4", "page byte 1", 16'(got), 16'h22);
        recv_byte(got, 1'b0);
        bus_stop();
        chk("R8", "read crosses page boundary", 16'(got), 16'hFF);
        read_at(16'h1000, a4);
        recv_byte(got, 1'b0);
        bus_stop();
        chk("R4", "third byte wrapped to page start", 16'(got), 16'h23);

        // R6: write lock
        lock = 1'b1;
        write_hdr(16'h0010, a3);
        chk("R6", "select and address acked", 16'(a3), 16'h7);
        send_byte(8'h77, ack);
        bus_stop();
        chk("R6", "data byte not acked", 16'(ack), 16'd0);
        poll(ack);
        chk("R6", "no programming started", 16'(ack), 16'd1);
        lock = 1'b0;
        read_at(16'h0010, a4);
        recv_byte(got, 1'b0);
        bus_stop();
        chk("R6", "memory unchanged", 16'(got), 16'h11);

        // R10: Stop in mid-byte aborts the write
        write_hdr(16'h0234, a3);
        send_byte(8'h55, ack);
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
        bus_stop();
        poll(ack);
        chk("R10", "no programming after Stop abort", 16'(ack), 16'd1);
        read_at(16'h0234, a4);
        recv_byte(got, 1'b0);
        bus_stop();
        chk("R10", "Stop abort kept old byte", 16'(got), 16'hA7);

        // R10: Start in mid-byte aborts the write
        write_hdr(16'h02FE, a3);
        send_byte(8'h66, ack);
        send_bit(1'b0); send_bit(1'b1);
        bus_start();
        send_byte(SEL_W, ack);
        bus_stop();
        chk("R10", "select acked after Start abort", 16'(ack), 16'd1);
        repeat (PROG_WAIT) @(negedge clk);
        read_at(16'h02FE, a4);
        recv_byte(got, 1'b0);
        bus_stop();
        chk("R10", "Start abort kept old byte", 16'(got), 16'h00);

        done = 1'b1;
        report();
    end

endmodule